// File: doc/BRIEF.md
# Single-Line Open-Drain Bus Master

This block is the master side of a single-wire, open-drain serial bus. It never drives the data line high. It asserts an output-enable that pulls the line low, and when it releases the line an external pullup restores the high level. All protocol timing runs from a one-microsecond tick, which a clock divider derives from the system clock. The divider ratio and every protocol interval are parameters.

Three commands are accepted through a start strobe, a two-bit command code and an eight-bit data input:

- **Bus reset.** A bus reset with presence detection.
- **Single bit write.** A write slot for one bit.
- **Byte write.** Eight back-to-back write slots, least significant bit first.

While a command runs, `busy` is high. A one-cycle `done` pulse marks completion. The result of the most recent presence check stays on `presence` until the next bus reset. The sampled line input passes through a small synchroniser before the sequencer reads it.

Top module: `swire_master`

## Requirements
- R1: While reset is asserted and after it, until a command is accepted, `line_oe` is 0 and `busy`, `done` and `presence` are 0.
- R2: Command code 0 (bus reset) pulls the line low (`line_oe`=1) for exactly T_RST_LOW microseconds (default 480), starting in the cycle after the accepting clock edge.
- R3: After a bus reset releases the line, the block keeps the line released for T_RST_REL microseconds (default 480) before completing. A bus reset therefore lasts 960 µs at the defaults.
- R4: `presence` is set to the inverse of the synchronised line level sampled T_PRES_SAMPLE microseconds (default 70) after the reset release. A device that holds the line low across that instant is reported as 1. A device that has not started, or has already finished, is reported as 0. `presence` is cleared when a bus reset starts and is left unchanged by write commands.
- R5: Command code 1 writes `din[0]` in one slot. The slot opens by pulling the line low. The line stays low for 6 µs for a 1 and for 60 µs for a 0, and the slot lasts 70 µs in total, so at least 10 µs of released recovery follows.
- R6: Command code 2 writes `din[7:0]` as eight consecutive slots, bit 0 first, lasting 560 µs. Each slot follows the timing of R5.
- R7: `busy` is high from the cycle after the accepting edge until the command completes. `done` is a single-cycle pulse, raised in the same cycle that `busy` falls.
- R8: A start strobe while `busy` is high is ignored and does not disturb the running command. Command code 3 is ignored: `busy` stays 0 and the line stays released.
- R9: One microsecond equals CLK_DIV clock cycles, and the divider restarts with every accepted command. A command of N microseconds therefore completes exactly N×CLK_DIV cycles after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, sampled while idle |
| cmd | input | 2 | Command code: 0 bus reset, 1 single bit, 2 byte, 3 none |
| din | input | 8 | Data to write (bit 0 for the single-bit command) |
| line_in | input | 1 | Sampled level of the bus line |
| line_oe | output | 1 | 1 pulls the bus line low; 0 releases it |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | A device answered the last bus reset |

## Verification
Every result has a known latency in clock cycles, counted from the edge that accepts `start`:

| Result | Edge at which it changes |
|---|---|
| `line_oe` asserted | The accepting edge itself |
| Each low phase ends | Its length × CLK_DIV edges later |
| `presence` update | (T_RST_LOW + T_PRES_SAMPLE) × CLK_DIV edges after acceptance, on a line value two clocks old |
| `done` rise and `busy` fall | The command length × CLK_DIV edges after acceptance |

The bench drives inputs on falling edges and samples on falling edges. It counts falling edges from the one that follows the accepting edge. It therefore expects `done` on sample N×CLK_DIV+1 and measures every low run of `line_oe` as a whole number of cycles equal to its microsecond length × CLK_DIV. A bench-side device model times its presence pulse from the observed release. The model's pulse windows are placed at least 5 µs away from the sampling instant, so the two-cycle synchroniser delay cannot change the expected outcome.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [1:0] {
        CMD_RESET = 2'd0,
        CMD_BIT   = 2'd1,
        CMD_BYTE  = 2'd2,
        CMD_NONE  = 2'd3
    } swire_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RST_LOW  = 2'd1,
        ST_RST_WAIT = 2'd2,
        ST_SLOT     = 2'd3
    } swire_state_e;

endpackage

// File: rtl/swire_tick_gen.sv
module swire_tick_gen #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = ~clear;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } tick_t;

            tick_t t_d, t_q;

            always_comb begin
                t_d = t_q;
                if (clear || t_q.cnt == LAST) t_d.cnt = '0;
                else                          t_d.cnt = t_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) t_q <= '0;
                else        t_q <= t_d;
            end

            assign tick = (t_q.cnt == LAST);

            AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                clear |=> !tick);                                   // R9
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);                                    // R9
        end
    endgenerate
endmodule

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            typedef struct packed {
                logic [STAGES-1:0] pipe;
            } sync_t;

            sync_t s_d, s_q;

            always_comb begin
                s_d = s_q;
                if (STAGES == 1) s_d.pipe[0] = d;
                else             s_d.pipe = {s_q.pipe[STAGES-2:0], d} & {STAGES{1'b1}};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '1;
                else        s_q <= s_d;
            end

            assign q = s_q.pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/swire_seq.sv
module swire_seq
    import swire_pkg::*;
#(
    parameter int T_RST_LOW     = 480,
    parameter int T_RST_REL     = 480,
    parameter int T_PRES_SAMPLE = 70,
    parameter int T_W1_LOW      = 6,
    parameter int T_W0_LOW      = 60,
    parameter int T_SLOT        = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] cmd,
    input  logic [7:0] din,
    input  logic       line_s,
    input  logic       tick,
    output logic       div_clear,
    output logic       line_oe,
    output logic       busy,
    output logic       done,
    output logic       presence
);
    localparam int MAX_A  = (T_RST_LOW > T_RST_REL) ? T_RST_LOW : T_RST_REL;
    localparam int MAX_US = (MAX_A > T_SLOT) ? MAX_A : T_SLOT;
    localparam int US_W   = $clog2(MAX_US + 1);

    localparam logic [US_W-1:0] RST_LOW_LAST = US_W'(T_RST_LOW - 1);
    localparam logic [US_W-1:0] RST_REL_LAST = US_W'(T_RST_REL - 1);
    localparam logic [US_W-1:0] SAMPLE_LAST  = US_W'(T_PRES_SAMPLE - 1);
    localparam logic [US_W-1:0] W1_LAST      = US_W'(T_W1_LOW - 1);
    localparam logic [US_W-1:0] W0_LAST      = US_W'(T_W0_LOW - 1);
    localparam logic [US_W-1:0] SLOT_LAST    = US_W'(T_SLOT - 1);

    typedef struct packed {
        swire_state_e    state;
        logic            oe;
        logic            done;
        logic            presence;
        logic [US_W-1:0] us;
        logic [7:0]      shift;
        logic [3:0]      left;
    } seq_t;

    localparam seq_t SEQ_RST = '{ST_IDLE, 1'b0, 1'b0, 1'b0, '0, '0, '0};

    seq_t r_d, r_q;
    logic [US_W-1:0] low_last;

    assign low_last = r_q.shift[0] ? W1_LAST : W0_LAST;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.oe = 1'b0;
                if (start) begin
                    unique case (cmd)
                        CMD_RESET: begin
                            r_d.state    = ST_RST_LOW;
                            r_d.oe       = 1'b1;
                            r_d.us       = '0;
                            r_d.presence = 1'b0;
                        end
                        CMD_BIT: begin
                            r_d.state = ST_SLOT;
                            r_d.oe    = 1'b1;
                            r_d.us    = '0;
                            r_d.shift = {7'b0, din[0]};
                            r_d.left  = 4'd1;
                        end
                        CMD_BYTE: begin
                            r_d.state = ST_SLOT;
                            r_d.oe    = 1'b1;
                            r_d.us    = '0;
                            r_d.shift = din;
                            r_d.left  = 4'd8;
                        end
                        default: ;
                    endcase
                end
            end
            ST_RST_LOW: begin
                if (tick) begin
                    if (r_q.us == RST_LOW_LAST) begin
                        r_d.state = ST_RST_WAIT;
                        r_d.oe    = 1'b0;
                        r_d.us    = '0;
                    end else begin
                        r_d.us = r_q.us + 1'b1;
                    end
                end
            end
            ST_RST_WAIT: begin
                if (tick) begin
                    if (r_q.us == SAMPLE_LAST) r_d.presence = ~line_s;
                    if (r_q.us == RST_REL_LAST) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.us    = '0;
                    end else begin
                        r_d.us = r_q.us + 1'b1;
                    end
                end
            end
            ST_SLOT: begin
                if (tick) begin
                    if (r_q.us == low_last) r_d.oe = 1'b0;
                    if (r_q.us == SLOT_LAST) begin
                        r_d.us = '0;
                        if (r_q.left == 4'd1) begin
                            r_d.state = ST_IDLE;
                            r_d.done  = 1'b1;
                            r_d.oe    = 1'b0;
                            r_d.left  = '0;
                        end else begin
                            r_d.shift = {1'b0, r_q.shift[7:1]};
                            r_d.left  = r_q.left - 1'b1;
                            r_d.oe    = 1'b1;
                        end
                    end else begin
                        r_d.us = r_q.us + 1'b1;
                    end
                end
            end
            default: r_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_RST;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign div_clear = (r_q.state == ST_IDLE);
    assign line_oe   = r_q.oe;
    assign done      = r_q.done;
    assign presence  = r_q.presence;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_oe);                                          // R1
    AST_RST_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RST_LOW) |-> line_oe);                       // R2
    AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RST_WAIT) |-> !line_oe);                     // R3
    AST_WRITE_KEEPS_PRES: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SLOT) |=> $stable(presence));                // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                              // R7
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cmd != CMD_NONE) |=> busy);                // R8
    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cmd == CMD_NONE) |=> (!busy && !line_oe)); // R8

endmodule

// File: rtl/swire_master.sv
module swire_master #(
    parameter int CLK_DIV       = 125,
    parameter int SYNC_STAGES   = 2,
    parameter int T_RST_LOW     = 480,
    parameter int T_RST_REL     = 480,
    parameter int T_PRES_SAMPLE = 70,
    parameter int T_W1_LOW      = 6,
    parameter int T_W0_LOW      = 60,
    parameter int T_SLOT        = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] cmd,
    input  logic [7:0] din,
    input  logic       line_in,
    output logic       line_oe,
    output logic       busy,
    output logic       done,
    output logic       presence
);
    logic tick;
    logic div_clear;
    logic line_s;

    swire_tick_gen #(
        .DIV (CLK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (div_clear),
        .tick  (tick)
    );

    swire_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    swire_seq #(
        .T_RST_LOW     (T_RST_LOW),
        .T_RST_REL     (T_RST_REL),
        .T_PRES_SAMPLE (T_PRES_SAMPLE),
        .T_W1_LOW      (T_W1_LOW),
        .T_W0_LOW      (T_W0_LOW),
        .T_SLOT        (T_SLOT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .din       (din),
        .line_s    (line_s),
        .tick      (tick),
        .div_clear (div_clear),
        .line_oe   (line_oe),
        .busy      (busy),
        .done      (done),
        .presence  (presence)
    );
endmodule

// File: tb/tb_swire_master.sv
module tb_swire_master;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic [7:0] din = 8'd0;
    logic       line_in;
    logic       line_oe, busy, done, presence;

    logic dev_on = 1'b0;
    logic dev_pull = 1'b0;
    int   pres_from = 30;
    int   pres_to   = 150;
    int   low_run = 0;
    int   dev_cnt = 0;
    logic dev_act = 1'b0;

    int total = 0;
    int fails = 0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    assign line_in = ~(line_oe | dev_pull);

    swire_master #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .din(din),
        .line_in(line_in), .line_oe(line_oe), .busy(busy), .done(done),
        .presence(presence)
    );

    // device model: answers a long low pulse with a presence pulse
    always @(negedge clk) begin
        if (line_oe) begin
            low_run  <= low_run + 1;
            dev_act  <= 1'b0;
            dev_cnt  <= 0;
            dev_pull <= 1'b0;
        end else begin
            low_run <= 0;
            if (low_run >= 400 * DIV && dev_on) begin
                dev_act  <= 1'b1;
                dev_cnt  <= 1;
                dev_pull <= 1'b0;
            end else if (dev_act) begin
                dev_cnt  <= dev_cnt + 1;
                dev_pull <= (dev_cnt + 1 >= pres_from * DIV) && (dev_cnt + 1 < pres_to * DIV);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // run one command; measures cycles to done and every low run of line_oe
    task automatic run_cmd(input logic [1:0] c, input logic [7:0] d, input int poke_at,
                           output int cyc, output int nlow, output logic [7:0] bits,
                           output int first_oe, output int bad_low, output int first_low,
                           output int busy_gap);
        int run;
        @(negedge clk);
        start = 1'b1; cmd = c; din = d;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; nlow = 0; bits = '0; bad_low = 0; first_low = 0; busy_gap = 0; run = 0;
        first_oe = int'(line_oe);
        for (int k = 0; k < 20000; k++) begin
            cyc++;
            if (poke_at != 0 && cyc == poke_at) begin start = 1'b1; cmd = 2'd0; end
            if (poke_at != 0 && cyc == poke_at + 1) start = 1'b0;
            if (line_oe) run++;
            else if (run > 0) begin
                if (nlow == 0) first_low = run;
                if (nlow < 8) bits[nlow] = (run <= 15 * DIV);
                if (run != 6 * DIV && run != 60 * DIV) bad_low++;
                nlow++;
                run = 0;
            end
            if (done) break;
            if (!busy) busy_gap++;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [1:0]  c;
        logic [7:0]  d;
        logic        dev;
        logic        pres;
        logic [11:0] us;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h00, 1'b1, 1'b1, 12'd960},
        '{2'd2, 8'hA5, 1'b0, 1'b1, 12'd560},
        '{2'd1, 8'h01, 1'b0, 1'b1, 12'd70},
        '{2'd1, 8'hFE, 1'b0, 1'b1, 12'd70},
        '{2'd2, 8'h3C, 1'b0, 1'b1, 12'd560},
        '{2'd0, 8'h00, 1'b0, 1'b0, 12'd960},
        '{2'd2, 8'hFF, 1'b0, 1'b0, 12'd560},
        '{2'd2, 8'h00, 1'b0, 1'b0, 12'd560},
        '{2'd0, 8'h5A, 1'b1, 1'b1, 12'd960}
    };

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int cyc, nlow, first_oe, bad_low, first_low, busy_gap;
        logic [7:0] bits;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", int'(line_oe), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 oe idle", int'(line_oe), 0);
        chk("R1 done idle", int'(done), 0);
        chk("R1 presence idle", int'(presence), 0);

        for (int i = 0; i < NV; i++) begin
            dev_on = VECS[i].dev; pres_from = 30; pres_to = 150;
            run_cmd(VECS[i].c, VECS[i].d, 0, cyc, nlow, bits, first_oe, bad_low, first_low, busy_gap);
            chk("R9 cycles to done", cyc, int'(VECS[i].us) * DIV + 1);
            chk("R7 busy until done", busy_gap, 0);
            chk("R5 line pulled at start", first_oe, 1);
            chk("R4 presence", int'(presence), int'(VECS[i].pres));
            if (VECS[i].c == 2'd0) begin
                chk("R2 reset low length", first_low, 480 * DIV);
                chk("R3 one low phase", nlow, 1);
            end else begin
                chk("R5 low widths", bad_low, 0);
                if (VECS[i].c == 2'd2) begin
                    chk("R6 slot count", nlow, 8);
                    chk("R6 byte lsb first", int'(bits), int'(VECS[i].d));
                end else begin
                    chk("R5 slot count", nlow, 1);
                    chk("R5 bit value", int'(bits[0]), int'(VECS[i].d[0]));
                end
            end
            @(negedge clk);
            chk("R7 done one cycle", int'(done), 0);
            chk("R7 busy low after done", int'(busy), 0);
        end

        // R4: device pulse starts after the sampling instant
        dev_on = 1'b1; pres_from = 80; pres_to = 200;
        run_cmd(2'd0, 8'h00, 0, cyc, nlow, bits, first_oe, bad_low, first_low, busy_gap);
        chk("R4 late device missed", int'(presence), 0);
        // R4: device pulse ends before the sampling instant
        pres_from = 20; pres_to = 65;
        run_cmd(2'd0, 8'h00, 0, cyc, nlow, bits, first_oe, bad_low, first_low, busy_gap);
        chk("R4 early device missed", int'(presence), 0);
        pres_from = 30; pres_to = 150;
        run_cmd(2'd0, 8'h00, 0, cyc, nlow, bits, first_oe, bad_low, first_low, busy_gap);
        chk("R4 device seen", int'(presence), 1);
        dev_on = 1'b0;

        // R8: start while busy must not disturb a byte write
        run_cmd(2'd2, 8'h96, 300, cyc, nlow, bits, first_oe, bad_low, first_low, busy_gap);
        chk("R8 busy start ignored, length", cyc, 560 * DIV + 1);
        chk("R8 busy start ignored, data", int'(bits), 8'h96);
        chk("R8 busy start ignored, presence", int'(presence), 1);

        // R8: command code 3 does nothing
        @(negedge clk);
        start = 1'b1; cmd = 2'd3; din = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        chk("R8 code 3 busy", int'(busy), 0);
        chk("R8 code 3 line", int'(line_oe), 0);
        repeat (20) @(negedge clk);
        chk("R8 code 3 still idle", int'(busy), 0);
        chk("R8 code 3 no done", int'(done), 0);

        summary();
    end
endmodule